// File: doc/BRIEF.md
# Dual-Root Timing Correlator with Peak and Mean Metrics

This block searches a stream of complex baseband samples for two known synchronization symbols at once. The samples arrive from the first receive antenna after low-pass filtering. Each accepted sample enters a sliding window of `NTAPS` samples. The window is multiplied against the complex conjugate of two stored time-domain reference sequences. Reference 0 stands for the partner node's sync symbol (chirp root 25). Reference 1 stands for the node's own transmitted sync symbol, which arrives as self-interference (chirp root 29). The correlation magnitude at each lag drives a running peak search and a running magnitude sum for each reference.

A search is opened with `start` and spans `NLAG` lags. When the last lag has been scored, the block raises `done` for one cycle. For each reference it then presents the peak magnitude, the lag where that peak occurred and the sum of all magnitudes in the window. Downstream logic can form the peak-to-mean ratio as `peak * NLAG / sum` and compare it against a threshold, so this block needs no divider. In the intended use the window covers one 2048-sample symbol plus its 512-sample cyclic prefix at 30.72 MS/s. The references are parameters holding 8-bit signed I/Q taps. The defaults are coarse quantized chirps, and a real integration overrides them with offline-computed tables.

Top module: `dual_root_sync_corr`

## Requirements
- R1: While reset is active and after it is released, `done` is low and all six result outputs are zero until the first search completes.
- R2: For window lag d, the complex correlation is the sum over taps k = 0..NTAPS-1 of x[d+k]·conj(r[k]). Here x[j] is the j-th sample accepted since `start`, and tap k is bits [8k+7:8k] of the I and Q reference parameters.
- R3: Correlation magnitude is computed as max(|re|,|im|) + floor(min(|re|,|im|)/2).
- R4: Each peak output holds the largest magnitude over the window, and the lag output holds its lag. When magnitudes tie, the earliest lag is kept.
- R5: Each sum output equals the sum of the NLAG magnitudes of lags 0..NLAG-1 for that reference.
- R6: The sample presented in the same cycle as `start` (with `in_valid` high) is sample 0. A search consumes exactly NLAG+NTAPS-1 accepted samples.
- R7: `done` is high for exactly one cycle. It rises at the second rising edge after the edge that accepts the search's last sample, and the results change at that same edge.
- R8: Cycles with `in_valid` low neither advance the search nor change its results.
- R9: Results hold between completions. Samples arriving after a search has ended and without a new `start` leave `done` low and the results unchanged.
- R10: Raising `start` during a search abandons it: the abandoned search never raises `done`, and it contributes nothing to the next search's results.
- R11: The two references are scored in parallel on the same samples, each with its own independent peak, lag and sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Opens a new search; the sample in this cycle is sample 0 |
| in_valid | input | 1 | Sample qualifier |
| in_i | input | IW | Signed in-phase sample |
| in_q | input | IW | Signed quadrature sample |
| done | output | 1 | One-cycle completion pulse |
| ptn_peak | output | MW | Peak magnitude, partner reference |
| ptn_lag | output | LW | Lag of that peak |
| ptn_sum | output | SW | Magnitude sum, partner reference |
| own_peak | output | MW | Peak magnitude, self-interference reference |
| own_lag | output | LW | Lag of that peak |
| own_sum | output | SW | Magnitude sum, self-interference reference |

## Verification
A sample passes three registers on its way to the outputs: the delay line, the correlation register, and the tracker with its result register. The results and `done` therefore appear after the second rising edge that follows the acceptance edge of the last sample. The bench drives inputs and samples outputs on falling edges. For every search it checks that `done` is low after the acceptance edge and after the next edge, high after the third edge, and low again after the fourth. It compares the peak, lag and sum of both references only in the cycle where `done` is high.

// File: rtl/sync_corr_pkg.sv
package sync_corr_pkg;

  localparam int REF_W        = 8;
  localparam int REF_MAX_TAPS = 64;

  typedef logic [REF_MAX_TAPS*REF_W-1:0] ref_tbl_t;

  // Eighth-turn unit circle scaled to 127, index in units of 45 degrees.
  function automatic logic [REF_W-1:0] unit_cos(int ph);
    case (ph & 7)
      0:       return 8'h7F;
      1, 7:    return 8'h5A;
      3, 5:    return 8'hA6;
      4:       return 8'h81;
      default: return 8'h00;
    endcase
  endfunction

  // Coarse quantized chirp used as a stand-in table until a computed one is supplied.
  function automatic ref_tbl_t chirp_tbl(int root, bit quad);
    ref_tbl_t v;
    int ph;
    v = '0;
    for (int n = 0; n < REF_MAX_TAPS; n++) begin
      ph = (root * n * (n + 1)) % 8;
      v[n*REF_W +: REF_W] = quad ? unit_cos(ph + 6) : unit_cos(ph);
    end
    return v;
  endfunction

endpackage

// File: rtl/sc_rst_sync.sv
module sc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= 2'b00;
    else        sr <= {sr[0], 1'b1};
  end

  assign rst_q_n = sr[1];
endmodule

// File: rtl/sc_corr_root.sv
module sc_corr_root
  import sync_corr_pkg::*;
#(
  parameter int       IW    = 12,
  parameter int       NTAPS = 32,
  parameter int       CW    = 26,
  parameter ref_tbl_t REF_I = '0,
  parameter ref_tbl_t REF_Q = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en,
  input  logic [NTAPS*IW-1:0]     win_i,
  input  logic [NTAPS*IW-1:0]     win_q,
  output logic signed [CW-1:0]    re,
  output logic signed [CW-1:0]    im
);
  logic signed [CW-1:0] sum_re, sum_im, xi, xq, ri, rq;

  // Window position k (0 = oldest sample) meets reference tap k, conjugated.
  always_comb begin
    sum_re = '0;
    sum_im = '0;
    xi = '0; xq = '0; ri = '0; rq = '0;
    for (int k = 0; k < NTAPS; k++) begin
      xi = CW'($signed(win_i[k*IW +: IW]));
      xq = CW'($signed(win_q[k*IW +: IW]));
      ri = CW'($signed(REF_I[k*REF_W +: REF_W]));
      rq = CW'($signed(REF_Q[k*REF_W +: REF_W]));
      sum_re = sum_re + xi * ri + xq * rq;
      sum_im = sum_im + xq * ri - xi * rq;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      re <= '0;
      im <= '0;
    end else if (en) begin
      re <= sum_re;
      im <= sum_im;
    end
  end
endmodule

// File: rtl/sc_mag.sv
module sc_mag #(
  parameter int CW = 26
) (
  input  logic signed [CW-1:0] re,
  input  logic signed [CW-1:0] im,
  output logic [CW:0]          mag
);
  logic [CW-1:0] ar, ai, mx, mn;

  always_comb begin
    ar  = re[CW-1] ? CW'(-re) : CW'(re);
    ai  = im[CW-1] ? CW'(-im) : CW'(im);
    mx  = (ar >= ai) ? ar : ai;
    mn  = (ar >= ai) ? ai : ar;
    mag = {1'b0, mx} + ({1'b0, mn} >> 1);
  end
endmodule

// File: rtl/sc_peak_track.sv
module sc_peak_track #(
  parameter int MW = 27,
  parameter int LW = 12,
  parameter int SW = 39
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic          fin,
  input  logic [MW-1:0] mag,
  input  logic [LW-1:0] lag,
  output logic [MW-1:0] res_peak,
  output logic [LW-1:0] res_lag,
  output logic [SW-1:0] res_sum
);
  logic [MW-1:0] best, best_d, pk_d;
  logic [LW-1:0] blag, blag_d, lg_d;
  logic [SW-1:0] acc, acc_d, sm_d;
  logic          first, take;

  always_comb begin
    first  = (lag == '0);
    take   = first || (mag > best);   // strict compare keeps the earliest lag
    best_d = best;
    blag_d = blag;
    acc_d  = acc;
    if (clr) begin
      best_d = '0;
      blag_d = '0;
      acc_d  = '0;
    end else if (en) begin
      acc_d = first ? SW'(mag) : acc + SW'(mag);
      if (take) begin
        best_d = mag;
        blag_d = lag;
      end
    end
    pk_d = fin ? best_d : res_peak;
    lg_d = fin ? blag_d : res_lag;
    sm_d = fin ? acc_d  : res_sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      best     <= '0;
      blag     <= '0;
      acc      <= '0;
      res_peak <= '0;
      res_lag  <= '0;
      res_sum  <= '0;
    end else begin
      best     <= best_d;
      blag     <= blag_d;
      acc      <= acc_d;
      res_peak <= pk_d;
      res_lag  <= lg_d;
      res_sum  <= sm_d;
    end
  end
endmodule

// File: rtl/dual_root_sync_corr.sv
module dual_root_sync_corr
  import sync_corr_pkg::*;
#(
  parameter int       IW        = 12,
  parameter int       NTAPS     = 32,
  parameter int       NLAG      = 2560,
  parameter ref_tbl_t PTN_REF_I = chirp_tbl(25, 1'b0),
  parameter ref_tbl_t PTN_REF_Q = chirp_tbl(25, 1'b1),
  parameter ref_tbl_t OWN_REF_I = chirp_tbl(29, 1'b0),
  parameter ref_tbl_t OWN_REF_Q = chirp_tbl(29, 1'b1),
  localparam int      CW        = IW + 9 + $clog2(NTAPS),
  localparam int      MW        = CW + 1,
  localparam int      LW        = $clog2(NLAG),
  localparam int      SW        = MW + $clog2(NLAG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic [IW-1:0] in_i,
  input  logic [IW-1:0] in_q,
  output logic          done,
  output logic [MW-1:0] ptn_peak,
  output logic [LW-1:0] ptn_lag,
  output logic [SW-1:0] ptn_sum,
  output logic [MW-1:0] own_peak,
  output logic [LW-1:0] own_lag,
  output logic [SW-1:0] own_sum
);
  localparam int CNTW  = $clog2(NLAG + NTAPS);
  localparam int LASTM = NLAG + NTAPS - 2;

  logic rst_q_n;
  sc_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  // Stage 0: sample delay line and search sequencing
  logic [NTAPS*IW-1:0] dl_i, dl_q, dl_i_d, dl_q_d;
  logic [CNTW-1:0]     cnt, cnt_d, m;
  logic                active, active_d, accept, is_last;
  logic                ev0, ev0_d, last0, last0_d;
  logic [LW-1:0]       lag0, lag0_d;
  // Stage 1: correlation register tags
  logic                ev1, ev1_d, last1, last1_d;
  logic [LW-1:0]       lag1;
  logic                fin;

  always_comb begin
    accept   = in_valid && (start || active);
    m        = start ? '0 : cnt;
    is_last  = (m == CNTW'(LASTM));
    dl_i_d   = dl_i;
    dl_q_d   = dl_q;
    if (in_valid) begin
      dl_i_d = {in_i, dl_i[NTAPS*IW-1:IW]};
      dl_q_d = {in_q, dl_q[NTAPS*IW-1:IW]};
    end
    cnt_d    = start ? '0 : cnt;
    active_d = start ? 1'b1 : active;
    if (accept) begin
      cnt_d = m + CNTW'(1);
      if (is_last) active_d = 1'b0;
    end
    ev0_d   = accept && (m >= CNTW'(NTAPS - 1));
    last0_d = accept && is_last;
    lag0_d  = LW'(m - CNTW'(NTAPS - 1));
    ev1_d   = ev0 && !start;
    last1_d = last0 && !start;
    fin     = ev1 && last1 && !start;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_i <= '0;
      dl_q <= '0;
    end else if (in_valid) begin
      dl_i <= dl_i_d;
      dl_q <= dl_q_d;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      cnt    <= '0;
      active <= 1'b0;
      ev0    <= 1'b0;
      last0  <= 1'b0;
      lag0   <= '0;
      ev1    <= 1'b0;
      last1  <= 1'b0;
      lag1   <= '0;
      done   <= 1'b0;
    end else begin
      cnt    <= cnt_d;
      active <= active_d;
      ev0    <= ev0_d;
      last0  <= last0_d;
      lag0   <= lag0_d;
      ev1    <= ev1_d;
      last1  <= last1_d;
      lag1   <= lag0;
      done   <= fin;
    end
  end

  // Stages 1 and 2, one lane per reference
  logic signed [CW-1:0] c_re [2];
  logic signed [CW-1:0] c_im [2];
  logic [MW-1:0]        mag  [2];
  logic [MW-1:0]        pk   [2];
  logic [LW-1:0]        lg   [2];
  logic [SW-1:0]        sm   [2];

  for (genvar g = 0; g < 2; g++) begin : g_root
    localparam ref_tbl_t RI = (g == 0) ? PTN_REF_I : OWN_REF_I;
    localparam ref_tbl_t RQ = (g == 0) ? PTN_REF_Q : OWN_REF_Q;

    sc_corr_root #(
      .IW(IW), .NTAPS(NTAPS), .CW(CW), .REF_I(RI), .REF_Q(RQ)
    ) u_corr (
      .clk(clk), .rst_n(rst_q_n), .en(ev0),
      .win_i(dl_i), .win_q(dl_q), .re(c_re[g]), .im(c_im[g])
    );

    sc_mag #(.CW(CW)) u_mag (.re(c_re[g]), .im(c_im[g]), .mag(mag[g]));

    sc_peak_track #(.MW(MW), .LW(LW), .SW(SW)) u_trk (
      .clk(clk), .rst_n(rst_q_n), .clr(start), .en(ev1 && !start),
      .fin(fin), .mag(mag[g]), .lag(lag1),
      .res_peak(pk[g]), .res_lag(lg[g]), .res_sum(sm[g])
    );
  end

  assign ptn_peak = pk[0];
  assign ptn_lag  = lg[0];
  assign ptn_sum  = sm[0];
  assign own_peak = pk[1];
  assign own_lag  = lg[1];
  assign own_sum  = sm[1];
endmodule

// File: rtl/sync_corr_chk.sv
module sync_corr_chk #(
  parameter int NLAG = 2560,
  parameter int MW   = 27,
  parameter int LW   = 12,
  parameter int SW   = 39
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          done,
  input logic [MW-1:0] ptn_peak,
  input logic [LW-1:0] ptn_lag,
  input logic [SW-1:0] ptn_sum,
  input logic [MW-1:0] own_peak,
  input logic [LW-1:0] own_lag,
  input logic [SW-1:0] own_sum
);
  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  res_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(ptn_peak) && $stable(ptn_lag) && $stable(ptn_sum) &&
               $stable(own_peak) && $stable(own_lag) && $stable(own_sum)));

  // R4
  lag_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((32'(ptn_lag) < NLAG) && (32'(own_lag) < NLAG)));

  // R5
  peak_le_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((SW'(ptn_peak) <= ptn_sum) && (SW'(own_peak) <= own_sum)));

  // R10
  restart_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done);
endmodule

bind dual_root_sync_corr sync_corr_chk #(
  .NLAG(NLAG), .MW(MW), .LW(LW), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .done(done),
  .ptn_peak(ptn_peak), .ptn_lag(ptn_lag), .ptn_sum(ptn_sum),
  .own_peak(own_peak), .own_lag(own_lag), .own_sum(own_sum)
);

// File: tb/tb_dual_root_sync_corr.sv
`timescale 1ns/1ps
module tb_dual_root_sync_corr;
  localparam int IW    = 12;
  localparam int NTAPS = 4;
  localparam int NLAG  = 8;
  localparam int NS    = NLAG + NTAPS - 1;
  localparam int CW    = IW + 9 + $clog2(NTAPS);
  localparam int MW    = CW + 1;
  localparam int LW    = $clog2(NLAG);
  localparam int SW    = MW + $clog2(NLAG + 1);

  // Tap k sits in bits [8k+7:8k]
  localparam logic [511:0] TB_PI = 512'h0105FE03;
  localparam logic [511:0] TB_PQ = 512'h02FF0400;
  localparam logic [511:0] TB_OI = 512'hFD0201FC;
  localparam logic [511:0] TB_OQ = 512'h00FB0202;
  int tap_i [2][NTAPS] = '{'{3, -2, 5, 1}, '{-4, 1, 2, -3}};
  int tap_q [2][NTAPS] = '{'{0, 4, -1, 2}, '{2, 2, -5, 0}};

  logic clk, rst_n, start, in_valid, done;
  logic [IW-1:0] in_i, in_q;
  logic [MW-1:0] ptn_peak, own_peak;
  logic [LW-1:0] ptn_lag, own_lag;
  logic [SW-1:0] ptn_sum, own_sum;

  dual_root_sync_corr #(
    .IW(IW), .NTAPS(NTAPS), .NLAG(NLAG),
    .PTN_REF_I(TB_PI), .PTN_REF_Q(TB_PQ), .OWN_REF_I(TB_OI), .OWN_REF_Q(TB_OQ)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_i(in_i), .in_q(in_q), .done(done),
    .ptn_peak(ptn_peak), .ptn_lag(ptn_lag), .ptn_sum(ptn_sum),
    .own_peak(own_peak), .own_lag(own_lag), .own_sum(own_sum)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int total = 0, fails = 0;
  bit finished = 0;
  int xs_i [NS];
  int xs_q [NS];
  longint ep_peak [2], ep_lag [2], ep_sum [2];
  int seed = 32'h1234_5678;

  task automatic chk(string req, string what, longint act, longint exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(bit st, bit v, int i, int q);
    @(negedge clk);
    start = st; in_valid = v; in_i = IW'(i); in_q = IW'(q);
  endtask

  // Model of R2..R5 from the requirement text
  task automatic compute_expect();
    for (int r = 0; r < 2; r++) begin
      longint best = 0, bl = 0, sum = 0;
      for (int d = 0; d < NLAG; d++) begin
        longint re = 0, im = 0, ar, ai, mx, mn, mg;
        for (int k = 0; k < NTAPS; k++) begin
          re += longint'(xs_i[d+k]) * tap_i[r][k] + longint'(xs_q[d+k]) * tap_q[r][k];
          im += longint'(xs_q[d+k]) * tap_i[r][k] - longint'(xs_i[d+k]) * tap_q[r][k];
        end
        ar = re < 0 ? -re : re;
        ai = im < 0 ? -im : im;
        mx = ar >= ai ? ar : ai;
        mn = ar >= ai ? ai : ar;
        mg = mx + mn / 2;
        sum += mg;
        if (d == 0 || mg > best) begin best = mg; bl = d; end
      end
      ep_peak[r] = best; ep_lag[r] = bl; ep_sum[r] = sum;
    end
  endtask

  task automatic check_results(string tag);
    chk("R4", {tag, " ptn peak"}, longint'(ptn_peak), ep_peak[0]);
    chk("R4", {tag, " ptn lag"},  longint'(ptn_lag),  ep_lag[0]);
    chk("R5", {tag, " ptn sum"},  longint'(ptn_sum),  ep_sum[0]);
    chk("R11", {tag, " own peak"}, longint'(own_peak), ep_peak[1]);
    chk("R11", {tag, " own lag"},  longint'(own_lag),  ep_lag[1]);
    chk("R11", {tag, " own sum"},  longint'(own_sum),  ep_sum[1]);
  endtask

  // Feeds one full search (R6), checks the done timing (R7) and results
  task automatic run_window(bit gaps, string tag);
    compute_expect();
    for (int s = 0; s < NS; s++) begin
      drive(s == 0, 1'b1, xs_i[s], xs_q[s]);
      if (gaps && (s % 3 == 1) && s < NS - 1) drive(1'b0, 1'b0, 0, 0);
    end
    drive(1'b0, 1'b0, 0, 0);
    chk("R7", {tag, " done after accept edge"}, longint'(done), 0);
    drive(1'b0, 1'b0, 0, 0);
    chk("R7", {tag, " done one edge later"}, longint'(done), 0);
    @(negedge clk);
    chk("R7", {tag, " done at second edge after accept"}, longint'(done), 1);
    check_results(tag);
    @(negedge clk);
    chk("R7", {tag, " done one cycle wide"}, longint'(done), 0);
  endtask

  task automatic fill_random();
    for (int s = 0; s < NS; s++) begin
      seed = seed * 1103515245 + 12345;
      xs_i[s] = ((seed >> 8) & 4095) - 2048;
      seed = seed * 1103515245 + 12345;
      xs_q[s] = ((seed >> 8) & 4095) - 2048;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; in_valid = 1'b0; in_i = '0; in_q = '0;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", longint'(done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "done after reset", longint'(done), 0);
    chk("R1", "ptn peak", longint'(ptn_peak), 0);
    chk("R1", "ptn lag",  longint'(ptn_lag), 0);
    chk("R1", "ptn sum",  longint'(ptn_sum), 0);
    chk("R1", "own peak", longint'(own_peak), 0);
    chk("R1", "own lag",  longint'(own_lag), 0);
    chk("R1", "own sum",  longint'(own_sum), 0);
  endtask

  // R2 R3 R6: pseudo-random samples
  task automatic t_random();
    fill_random();
    run_window(1'b0, "R2 random");
  endtask

  // R4: identical windows everywhere, earliest lag must win
  task automatic t_flat();
    for (int s = 0; s < NS; s++) begin xs_i[s] = 100; xs_q[s] = -37; end
    run_window(1'b0, "R4 flat");
  endtask

  // R3: full-scale alternating samples
  task automatic t_extreme();
    for (int s = 0; s < NS; s++) begin
      xs_i[s] = (s % 2 == 0) ? -2048 : 2047;
      xs_q[s] = (s % 3 == 0) ? 2047 : -2048;
    end
    run_window(1'b0, "R3 extreme");
  endtask

  // R8: idle cycles between samples do not change the result
  task automatic t_gaps();
    fill_random();
    run_window(1'b1, "R8 gaps");
  endtask

  // R10: abandon a search mid-way, then run a full one
  task automatic t_restart();
    drive(1'b1, 1'b1, 2047, 2047);
    for (int s = 0; s < 6; s++) begin
      drive(1'b0, 1'b1, -1500 + s * 300, 900 - s * 200);
      chk("R10", "no done during abandoned search", longint'(done), 0);
    end
    fill_random();
    run_window(1'b0, "R10 restart");
  endtask

  // R9: samples with no open search are ignored
  task automatic t_ignore();
    for (int s = 0; s < 6; s++) begin
      drive(1'b0, 1'b1, 1111 - s * 400, -777 + s * 250);
      chk("R9", "done stays low", longint'(done), 0);
    end
    drive(1'b0, 1'b0, 0, 0);
    repeat (3) @(negedge clk);
    chk("R9", "done stays low after idle", longint'(done), 0);
    check_results("R9 hold");
  endtask

  initial begin
    t_reset();
    t_random();
    t_flat();
    t_extreme();
    t_gaps();
    t_restart();
    t_ignore();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule